// File: doc/BRIEF.md
# Statistics Counter Bank with Indirect Read

This block keeps a set of traffic statistics for a small switch. There are two kinds of counter. Each port has its own group of counters, and these clear themselves once they are fetched. A second, shared group counts dropped packets, and those counters are never cleared. Each counter has its own one-cycle event strobe from the datapath. A counter advances by one in every clock cycle in which its strobe is high.

A host reaches the counters through a small byte-wide synchronous register window. The host first writes a selector byte, which chooses the counter kind. It then writes an index byte, and that second write starts a fetch. After a fixed latency the selected value appears in a 32-bit holding word. The host reads the holding word as four bytes. For per-port counters the word carries a valid flag, which tells the host whether the fetch has finished. It also carries an overflow flag, which is sticky until the counter is fetched.

Widths, port count, dropped-counter count and fetch latency are parameters. The default per-port counter is 30 bits, and the default dropped counter is 16 bits.

Top module: `stat_counter_bank`

## Requirements
- R1: After reset every counter is zero, and the four data bytes at 0x80..0x83 read 0x00.
- R2: Writing 0x1C to 0x79 and then an index to 0x7A selects per-port counter number index. Index bits 7:5 are the port slot and bits 4:0 are the counter within the slot. Each port has 32 counters. A counter advances by one in each cycle in which its strobe `port_evt[index]` is high.
- R3: A write to 0x7A blanks the holding word. From the cycle after that write until the fetch completes, all four data bytes read 0x00, so the valid flag (byte 0x80 bit 6) reads 0.
- R4: The fetch completes on the fourth clock edge after the edge that takes the 0x7A write. The holding word then shows the count as it stood before that edge. The byte layout is: 0x80 = {overflow, valid=1, count[29:24]}, 0x81 = count[23:16], 0x82 = count[15:8], 0x83 = count[7:0].
- R5: On the completing edge, the fetched per-port counter and its overflow flag clear to zero.
- R6: A per-port counter that advances past its all-ones value wraps to zero and sets its overflow flag. The flag stays set until that counter is fetched.
- R7: If a per-port counter's strobe is high on the edge that clears it, the counter is left at 1.
- R8: Selector 0x1D with an index below the dropped-counter count selects `drop_evt[index]`. Its 16-bit value appears in 0x82/0x83, and 0x80/0x81 read 0x00, so no flags are shown. Fetching it does not change it.
- R9: A dropped-packet counter wraps from 0xFFFF to 0x0000 and reports nothing.
- R10: A fetch with any selector other than 0x1C or 0x1D yields a word of zero. A 0x1C fetch whose index is beyond the last port yields only the valid flag (0x40000000). A 0x1D fetch whose index is out of range yields zero. None of these fetches clears any counter.
- R11: A write to 0x7A while a fetch is still pending restarts the four-edge wait with the new index. The earlier selection is neither captured nor cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_evt | input | NUM_PORTS*32 | Per-port counter event strobes, bit = slot*32+counter |
| drop_evt | input | NUM_DROP | Dropped-packet counter event strobes |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 8 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for host_addr, combinational |

## Verification
A 0x7A write is taken on one edge (E0) and the holding word is blank from just after E0. The captured value appears just after the fourth following edge (E4), together with the clear of the source counter. Every strobe sampled up to E3 is included in the captured value. A strobe sampled at E4 survives in the cleared counter as 1.

The bench mirrors this in a per-edge model. It updates the model right after each rising edge, and then compares the window at the following falling edge. The window is checked on E0 through E3, to confirm it stays blank, and again after E4, to confirm the captured value. The bench widens nothing. Instead it narrows the per-port count width, so that a wrap fits in a short run.

// File: rtl/stat_pkg.sv
`timescale 1ns/1ps
// Shared constants for the statistics counter bank: register window
// addresses, selector codes and the fixed slot layout of the index byte.
package stat_pkg;
    localparam logic [7:0] ADDR_SEL   = 8'h79;
    localparam logic [7:0] ADDR_IDX   = 8'h7A;
    localparam logic [7:0] ADDR_B3    = 8'h80;
    localparam logic [7:0] ADDR_B2    = 8'h81;
    localparam logic [7:0] ADDR_B1    = 8'h82;
    localparam logic [7:0] ADDR_B0    = 8'h83;
    localparam logic [7:0] SEL_PORT   = 8'h1C;
    localparam logic [7:0] SEL_DROP   = 8'h1D;
    localparam int         SLOT_CNTS  = 32;
    localparam int         FIELD_W    = 30;
    localparam int         DROP_FIELD = 16;
endpackage

// File: rtl/stat_cnt_cell.sv
`timescale 1ns/1ps
// One per-port statistics counter with a sticky overflow flag.
// Assumes clr comes from the fetch logic; an event coinciding with the
// clear is kept as a count of one.
module stat_cnt_cell #(
    parameter int W = 30
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] cnt,
    output logic         ovf
);

    // Count events, wrap with sticky flag, clear on fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (clr) begin
            cnt <= W'(inc);
            ovf <= 1'b0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
            if (&cnt) ovf <= 1'b1;
        end
    end

    a_r5_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!ovf && (cnt <= W'(1))));
    a_r7_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && inc) |=> (cnt == W'(1)));
    a_r6_wrap_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc && (&cnt)) |=> (ovf && (cnt == '0)));

endmodule

// File: rtl/stat_port_bank.sv
`timescale 1ns/1ps
// Array of per-port counters laid out slot-major (slot*32 + counter).
// Provides a combinational read of one counter and clears that same
// counter when clr_en is high. Assumes rd_idx is held during the clear.
module stat_port_bank
    import stat_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int W         = 30,
    localparam int N        = NUM_PORTS * SLOT_CNTS,
    localparam int IDX_W    = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     evt,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             clr_en,
    output logic [W-1:0]     rd_cnt,
    output logic             rd_ovf
);

    logic [W-1:0] cnt_q [N];
    logic [N-1:0] ovf_q;

    for (genvar i = 0; i < N; i++) begin : g_cell
        stat_cnt_cell #(.W(W)) u_cell (
            .clk (clk),
            .rst_n (rst_n),
            .inc (evt[i]),
            .clr (clr_en && (rd_idx == IDX_W'(i))),
            .cnt (cnt_q[i]),
            .ovf (ovf_q[i])
        );
    end

    // Select the addressed counter for the fetch logic.
    always_comb begin
        rd_cnt = '0;
        rd_ovf = 1'b0;
        if (int'(rd_idx) < N) begin
            rd_cnt = cnt_q[rd_idx];
            rd_ovf = ovf_q[rd_idx];
        end
    end

endmodule

// File: rtl/stat_drop_bank.sv
`timescale 1ns/1ps
// Shared dropped-packet counters: free-running, wrap silently, never
// cleared by a fetch. Assumes NUM_DROP >= 2.
module stat_drop_bank #(
    parameter int NUM_DROP = 6,
    parameter int W        = 16,
    localparam int IDX_W   = $clog2(NUM_DROP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_DROP-1:0] evt,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [W-1:0]      rd_cnt
);

    logic [W-1:0] cnt_q [NUM_DROP];

    for (genvar i = 0; i < NUM_DROP; i++) begin : g_cnt
        // Advance this counter on its strobe, wrapping at all-ones.
        always_ff @(posedge clk) begin
            if (!rst_n)      cnt_q[i] <= '0;
            else if (evt[i]) cnt_q[i] <= cnt_q[i] + 1'b1;
        end

        a_r8_drop_holds: assert property (@(posedge clk) disable iff (!rst_n)
            !evt[i] |=> $stable(cnt_q[i]));
    end

    // Select the addressed counter for the fetch logic.
    always_comb begin
        rd_cnt = '0;
        if (int'(rd_idx) < NUM_DROP) rd_cnt = cnt_q[rd_idx];
    end

endmodule

// File: rtl/stat_fetch_ctrl.sv
`timescale 1ns/1ps
// Host register window and fetch sequencer. The selector write picks the
// counter kind, the index write starts a FETCH_LAT-edge wait, after which
// the selected value is latched into the holding word and, for per-port
// counters, the source is cleared. Assumes NUM_PORTS*32 <= 256, DW <= 16.
module stat_fetch_ctrl
    import stat_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int PCW       = 30,
    parameter int NUM_DROP  = 6,
    parameter int DW        = 16,
    parameter int FETCH_LAT = 4,
    localparam int NP_CNTS  = NUM_PORTS * SLOT_CNTS,
    localparam int PIDX_W   = $clog2(NP_CNTS),
    localparam int DIDX_W   = $clog2(NUM_DROP),
    localparam int WAIT_W   = $clog2(FETCH_LAT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [7:0]        host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic [PCW-1:0]    p_cnt,
    input  logic              p_ovf,
    input  logic [DW-1:0]     d_cnt,
    output logic [PIDX_W-1:0] p_idx,
    output logic [DIDX_W-1:0] d_idx,
    output logic              p_clr
);

    logic [7:0]        sel_q;
    logic [7:0]        idx_q;
    logic [WAIT_W-1:0] wait_q;
    logic [31:0]       hold_q;
    logic              trig;
    logic              capture;
    logic              port_ok;
    logic              drop_ok;
    logic [FIELD_W-1:0]    pc_ext;
    logic [DROP_FIELD-1:0] dc_ext;
    logic [31:0]       cap_word;

    assign trig    = host_wr && (host_addr == ADDR_IDX);
    assign capture = (wait_q == WAIT_W'(1)) && !trig;
    assign port_ok = (sel_q == SEL_PORT) && (int'(idx_q) < NP_CNTS);
    assign drop_ok = (sel_q == SEL_DROP) && (int'(idx_q) < NUM_DROP);
    assign p_idx   = idx_q[PIDX_W-1:0];
    assign d_idx   = idx_q[DIDX_W-1:0];
    assign p_clr   = capture && port_ok;

    // Remember the selector byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                                       sel_q <= '0;
        else if (host_wr && (host_addr == ADDR_SEL))      sel_q <= host_wdata;
    end

    // Remember the index byte that started the fetch.
    always_ff @(posedge clk) begin
        if (!rst_n)    idx_q <= '0;
        else if (trig) idx_q <= host_wdata;
    end

    // Fetch latency timer: loaded by the index write, counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              wait_q <= '0;
        else if (trig)           wait_q <= WAIT_W'(FETCH_LAT);
        else if (wait_q != '0)   wait_q <= wait_q - 1'b1;
    end

    // Zero-extend counter values into their word fields.
    always_comb begin
        pc_ext = '0;
        pc_ext[PCW-1:0] = p_cnt;
        dc_ext = '0;
        dc_ext[DW-1:0] = d_cnt;
    end

    // Form the word that the fetch will latch.
    always_comb begin
        if (port_ok)                cap_word = {p_ovf, 1'b1, pc_ext};
        else if (sel_q == SEL_PORT) cap_word = 32'h4000_0000;
        else if (drop_ok)           cap_word = {16'h0000, dc_ext};
        else                        cap_word = '0;
    end

    // Holding word: blanked on trigger, loaded at fetch completion.
    always_ff @(posedge clk) begin
        if (!rst_n)       hold_q <= '0;
        else if (trig)    hold_q <= '0;
        else if (capture) hold_q <= cap_word;
    end

    // Byte-wide read mux of the register window.
    always_comb begin
        case (host_addr)
            ADDR_SEL: host_rdata = sel_q;
            ADDR_IDX: host_rdata = idx_q;
            ADDR_B3:  host_rdata = hold_q[31:24];
            ADDR_B2:  host_rdata = hold_q[23:16];
            ADDR_B1:  host_rdata = hold_q[15:8];
            ADDR_B0:  host_rdata = hold_q[7:0];
            default:  host_rdata = 8'h00;
        endcase
    end

    a_r3_blank_after_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (hold_q == '0));
    a_r11_no_valid_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_q != '0) |-> !hold_q[30]);
    a_r4_valid_at_count_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_q[30]) |-> ($past(wait_q) == WAIT_W'(1)));
    a_r5_clear_with_capture: assert property (@(posedge clk) disable iff (!rst_n)
        p_clr |=> hold_q[30]);

endmodule

// File: rtl/stat_counter_bank.sv
`timescale 1ns/1ps
// Top of the statistics counter bank: per-port clear-on-fetch counters,
// shared dropped-packet counters, and the indirect host read window.
// Assumes one host write per cycle and single-cycle event strobes.
module stat_counter_bank
    import stat_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int PCW       = 30,
    parameter int NUM_DROP  = 6,
    parameter int DW        = 16,
    parameter int FETCH_LAT = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_PORTS*SLOT_CNTS-1:0] port_evt,
    input  logic [NUM_DROP-1:0]           drop_evt,
    input  logic                          host_wr,
    input  logic [7:0]                    host_addr,
    input  logic [7:0]                    host_wdata,
    output logic [7:0]                    host_rdata
);

    localparam int NP_CNTS = NUM_PORTS * SLOT_CNTS;
    localparam int PIDX_W  = $clog2(NP_CNTS);
    localparam int DIDX_W  = $clog2(NUM_DROP);

    logic [PCW-1:0]    p_cnt;
    logic              p_ovf;
    logic [DW-1:0]     d_cnt;
    logic [PIDX_W-1:0] p_idx;
    logic [DIDX_W-1:0] d_idx;
    logic              p_clr;

    stat_port_bank #(.NUM_PORTS(NUM_PORTS), .W(PCW)) u_port (
        .clk (clk),
        .rst_n (rst_n),
        .evt (port_evt),
        .rd_idx (p_idx),
        .clr_en (p_clr),
        .rd_cnt (p_cnt),
        .rd_ovf (p_ovf)
    );

    stat_drop_bank #(.NUM_DROP(NUM_DROP), .W(DW)) u_drop (
        .clk (clk),
        .rst_n (rst_n),
        .evt (drop_evt),
        .rd_idx (d_idx),
        .rd_cnt (d_cnt)
    );

    stat_fetch_ctrl #(
        .NUM_PORTS(NUM_PORTS), .PCW(PCW), .NUM_DROP(NUM_DROP),
        .DW(DW), .FETCH_LAT(FETCH_LAT)
    ) u_ctrl (
        .clk (clk),
        .rst_n (rst_n),
        .host_wr (host_wr),
        .host_addr (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .p_cnt (p_cnt),
        .p_ovf (p_ovf),
        .d_cnt (d_cnt),
        .p_idx (p_idx),
        .d_idx (d_idx),
        .p_clr (p_clr)
    );

endmodule

// File: tb/tb_stat_counter_bank.sv
`timescale 1ns/1ps
module tb_stat_counter_bank;
    localparam int NP   = 3;
    localparam int NPC  = NP * 32;
    localparam int PCW  = 10;
    localparam int ND   = 6;
    localparam int PMAX = (1 << PCW) - 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NPC-1:0] pevt = '0;
    logic [ND-1:0]  devt = '0;
    logic           wr = 1'b0;
    logic [7:0]     addr = 8'h00;
    logic [7:0]     wdata = 8'h00;
    logic [7:0]     rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int unsigned mp [NPC];
    bit          mo [NPC];
    int unsigned md [ND];
    int          pend = 0;
    logic [7:0]  mctl = 8'h00;
    logic [7:0]  midx = 8'h00;
    logic [31:0] exp_word = 32'h0;

    always #4 clk = ~clk;

    stat_counter_bank #(.NUM_PORTS(NP), .PCW(PCW), .NUM_DROP(ND), .DW(16), .FETCH_LAT(4)) dut (
        .clk (clk), .rst_n (rst_n), .port_evt (pevt), .drop_evt (devt),
        .host_wr (wr), .host_addr (addr), .host_wdata (wdata), .host_rdata (rdata)
    );

    function automatic logic [31:0] mk_word(logic [7:0] c, logic [7:0] ix);
        if (c == 8'h1C) begin
            if (int'(ix) < NPC) return {mo[ix], 1'b1, 30'(mp[ix])};
            return 32'h4000_0000;
        end
        if (c == 8'h1D && int'(ix) < ND) return {16'h0, 16'(md[ix])};
        return 32'h0;
    endfunction

    // One clock edge: model update after the rising edge, return at falling edge.
    task automatic tick();
        bit trig;
        int clr_i;
        @(posedge clk);
        trig  = wr && (addr == 8'h7A);
        clr_i = -1;
        if (rst_n) begin
            if (pend == 1 && !trig) begin
                exp_word = mk_word(mctl, midx);
                if (mctl == 8'h1C && int'(midx) < NPC) clr_i = int'(midx);
            end
            for (int i = 0; i < NPC; i++) begin
                if (i == clr_i) begin
                    mp[i] = pevt[i] ? 1 : 0;
                    mo[i] = 1'b0;
                end else if (pevt[i]) begin
                    if (mp[i] == PMAX) begin mp[i] = 0; mo[i] = 1'b1; end
                    else mp[i] = mp[i] + 1;
                end
            end
            for (int i = 0; i < ND; i++) if (devt[i]) md[i] = (md[i] + 1) & 32'hFFFF;
            if (pend != 0) pend = pend - 1;
            if (wr && addr == 8'h79) mctl = wdata;
            if (trig) begin midx = wdata; pend = 4; exp_word = 32'h0; end
        end
        @(negedge clk);
    endtask

    task automatic host_write(logic [7:0] a, logic [7:0] d);
        wr = 1'b1; addr = a; wdata = d;
        tick();
        wr = 1'b0;
    endtask

    task automatic chk_word(string tag);
        logic [31:0] got;
        for (int b = 0; b < 4; b++) begin
            addr = 8'h80 + 8'(b);
            #0.2;
            got[31-8*b -: 8] = rdata;
        end
        checks++;
        if (got !== exp_word) begin
            fails++;
            $display("FAIL %s: window actual=%08h expected=%08h", tag, got, exp_word);
        end
    endtask

    task automatic rand_evt(bit on);
        if (on) begin
            pevt = {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom};
            devt = 6'($urandom);
        end
    endtask

    // Full fetch: selector, trigger, blank window on E0..E3, value after E4.
    task automatic fetch(logic [7:0] c, logic [7:0] ix, string tag, bit rnd);
        host_write(8'h79, c);
        rand_evt(rnd);
        host_write(8'h7A, ix);
        chk_word("R3 blank after trigger");
        for (int k = 0; k < 3; k++) begin
            rand_evt(rnd);
            tick();
            chk_word("R3 blank while pending");
        end
        rand_evt(rnd);
        tick();
        chk_word(tag);
    endtask

    initial begin
        #1_600_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL R4 watchdog: run did not finish actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24681));
        for (int i = 0; i < NPC; i++) begin mp[i] = 0; mo[i] = 1'b0; end
        for (int i = 0; i < ND; i++) md[i] = 0;
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        chk_word("R1 reset window");
        fetch(8'h1C, 8'h00, "R1 zero counter after reset", 1'b0);

        // R2/R4: counter 0x2E counts seven strobes
        pevt[8'h2E] = 1'b1;
        repeat (7) tick();
        pevt = '0;
        fetch(8'h1C, 8'h2E, "R2 R4 per-port count", 1'b0);
        // R5: cleared by the fetch
        fetch(8'h1C, 8'h2E, "R5 cleared after fetch", 1'b0);

        // R7: strobe only on the completing edge
        host_write(8'h79, 8'h1C);
        host_write(8'h7A, 8'h05);
        repeat (3) tick();
        pevt[5] = 1'b1;
        tick();
        pevt = '0;
        chk_word("R4 fetch with late strobe");
        fetch(8'h1C, 8'h05, "R7 coincident strobe kept as one", 1'b0);

        // R6: wrap of counter 0x4A
        pevt[8'h4A] = 1'b1;
        repeat (PMAX + 6) tick();
        pevt = '0;
        fetch(8'h1C, 8'h4A, "R6 overflow after wrap", 1'b0);
        fetch(8'h1C, 8'h4A, "R5 overflow cleared by fetch", 1'b0);

        // R8: dropped counter not cleared
        devt[0] = 1'b1;
        repeat (9) tick();
        devt = '0;
        fetch(8'h1D, 8'h00, "R8 dropped counter value", 1'b0);
        fetch(8'h1D, 8'h00, "R8 dropped counter kept", 1'b0);

        // R10: unmatched selections
        pevt[3] = 1'b1; tick(); tick(); pevt = '0;
        fetch(8'h55, 8'h03, "R10 unknown selector", 1'b0);
        fetch(8'h1C, 8'h60, "R10 port index beyond range", 1'b0);
        fetch(8'h1D, 8'h06, "R10 drop index beyond range", 1'b0);
        fetch(8'h1C, 8'h03, "R10 no clear by bad fetch", 1'b0);

        // R11: restart during pending fetch
        pevt[8'h11] = 1'b1; pevt[8'h22] = 1'b1;
        host_write(8'h79, 8'h1C);
        host_write(8'h7A, 8'h11);
        tick(); tick();
        pevt = '0;
        host_write(8'h7A, 8'h22);
        chk_word("R11 blank on restart");
        for (int k = 0; k < 3; k++) begin tick(); chk_word("R11 still pending"); end
        tick();
        chk_word("R11 restarted index captured");
        fetch(8'h1C, 8'h11, "R11 first index untouched", 1'b0);

        // R9: dropped counter wrap
        devt[1] = 1'b1;
        repeat (65538) tick();
        devt = '0;
        fetch(8'h1D, 8'h01, "R9 dropped wrap silent", 1'b0);

        // Random mix of strobes and selections
        for (int it = 0; it < 150; it++) begin
            int gap;
            int pick;
            logic [7:0] c;
            logic [7:0] ix;
            gap = int'($urandom % 12);
            for (int g = 0; g < gap; g++) begin rand_evt(1'b1); tick(); end
            pick = int'($urandom % 10);
            if (pick < 6)      begin c = 8'h1C; ix = 8'($urandom % NPC); end
            else if (pick < 9) begin c = 8'h1D; ix = 8'($urandom % ND); end
            else               begin c = 8'($urandom); ix = 8'($urandom); end
            fetch(c, ix, "R4 random fetch", 1'b1);
        end
        pevt = '0; devt = '0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule